// File: doc/BRIEF.md
# Quadrant-Refreshed Masked AND Gadget

This block computes a bitwise AND of two secret words held as Boolean sharings of `D` shares of `W` bits each. The result is a fresh `D`-share sharing. `D` must be a power of two, from 2 to 32. The XOR of the output shares equals the AND of the XOR of the x shares and the XOR of the y shares.

The gadget is built to make averaging attacks harder. It does not reuse each input share across a full row of cross products. Instead it builds the full `D`×`D` product matrix by recursive halving. The two halves of each input are re-masked between sub-blocks, so every share value takes part in only a fixed number of products. A pairwise compression then folds the matrix into `D` output shares, using fresh random words.

The recursion is flattened into a fixed schedule:
- one matrix entry per clock;
- one random word per accepted handshake during re-masking and compression.

Random words arrive on a valid/ready port. A one-cycle `done` pulse marks a result, which is held until the next operation completes.

Top module: `rrm_and`

## Requirements
- R1: While reset is high, and in the first cycle after it, `done` and `rnd_ready` are 0 and `c_sh` is all zeros.
- R2: After each operation, the XOR of the `D` output words equals (XOR of x shares) AND (XOR of y shares). Share i occupies bits [i*W+W-1 : i*W] of each share bus.
- R3: The matrix for a block of n shares is built from its halves in this order:
  - low x with low y;
  - re-mask the low x half, then the low y half;
  - low x with high y;
  - high x with low y;
  - re-mask the high x half, then the high y half;
  - high x with high y.
  A block of one share gives the product of that x and y working share. Re-masked halves overwrite the working shares.
- R4: A re-mask of h shares takes one random word per pair (a,b) with a<b, pairs in ascending order of a and then b, and XORs it into both shares. It leaves the XOR of the x shares and of the y shares unchanged. Halves of one share need no random word.
- R5: Compression starts from the diagonal of the matrix. Then, for each pair i<j in ascending order, one random word s is taken: share i absorbs s, and share j absorbs s XOR M(i,j) XOR M(j,i).
- R6: One operation consumes exactly (log2 D − 1)·D²/2 − (D/2 − 1)·D + D(D−1)/2 random words (10 for D=4, 68 for D=8).
- R7: A random word is consumed only in a cycle where `rnd_valid` and `rnd_ready` are both 1. `rnd_ready` is 0 while idle. Stalls on `rnd_valid` do not change the result.
- R8: `done` is high for exactly one cycle per operation, in the cycle `c_sh` first shows the result. `c_sh` then stays stable while the block is idle.
- R9: `start` is ignored while an operation is running. The result then depends only on the shares captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; captures x_sh and y_sh when idle |
| x_sh | input | D*W | x sharing, share i at bits i*W+:W |
| y_sh | input | D*W | y sharing, share i at bits i*W+:W |
| rnd_data | input | W | Fresh random word |
| rnd_valid | input | 1 | rnd_data holds a word |
| rnd_ready | output | 1 | Block accepts a random word this cycle |
| c_sh | output | D*W | Output sharing, share i at bits i*W+:W |
| done | output | 1 | One-cycle pulse when c_sh holds a new result |

## Verification
The gadget is run with D=4 and D=8. The bench predicts every output share from an independent stack-based model of the recursion, which uses the same random stream.

Different random streams separate different kinds of fault:
- An all-zero random stream turns every re-mask into the identity. The exact shares then expose any error in compression order or pairing, apart from the masks.
- A hashed stream makes each output share depend on where every random word lands. A swapped quadrant, a refresh at the wrong point, or a wrong random order changes individual shares, even when the recombined AND still matches.

Further patterns target the edges:
- All-ones and all-zero sharings cover the degenerate secrets.
- Random stalls on `rnd_valid` show that the schedule is independent of handshake timing.
- A start pulse mid-run shows that a busy block ignores new operands.

// File: rtl/rrm_pkg.sv
`timescale 1ns/1ps
package rrm_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAF,
        S_REF,
        S_CINIT,
        S_CPAIR
    } rrm_state_e;

    // number of random words one operation draws: re-masking plus compression
    function automatic int rand_words(input int d);
        int lg;
        lg = $clog2(d);
        return (lg - 1) * d * d / 2 - (d / 2 - 1) * d + d * (d - 1) / 2;
    endfunction

endpackage

// File: rtl/rrm_leaf_sched.sv
`timescale 1ns/1ps
// Decodes a leaf counter into matrix coordinates and the re-mask that follows it.
// The counter interleaves x and y index bits, x bit above y bit per level, so that
// counting visits quadrants 00,01,10,11 at every level of the recursion.
module rrm_leaf_sched #(
    parameter int LOGD = 2
) (
    input  logic [2*LOGD-1:0] k,
    output logic [LOGD-1:0]   row,
    output logic [LOGD-1:0]   col,
    output logic              remask,
    output logic [LOGD-1:0]   xbase,
    output logic [LOGD-1:0]   ybase,
    output logic [LOGD:0]     half
);
    logic            found;
    logic            hi_sel;
    logic [1:0]      q;
    logic [LOGD-1:0] lowmask;

    always_comb begin
        row     = '0;
        col     = '0;
        found   = 1'b0;
        hi_sel  = 1'b0;
        remask  = 1'b0;
        half    = '0;
        q       = '0;
        for (int lv = 0; lv < LOGD; lv++) begin
            row[lv] = k[2*lv+1];
            col[lv] = k[2*lv];
        end
        // lowest level whose quadrant is not the last one closes a sub-block
        for (int lv = 0; lv < LOGD; lv++) begin
            q = k[2*lv +: 2];
            if (!found && q != 2'b11) begin
                found = 1'b1;
                if (lv > 0 && q[0] == 1'b0) begin
                    remask = 1'b1;
                    hi_sel = q[1];
                    half   = (LOGD+1)'(1) << lv;
                end
            end
        end
        lowmask = half[LOGD-1:0] - LOGD'(1);
        xbase   = row & ~lowmask;
        ybase   = (col & ~lowmask) + (hi_sel ? half[LOGD-1:0] : '0);
    end
endmodule

// File: rtl/rrm_pair_walk.sv
`timescale 1ns/1ps
// Steps through index pairs (a,b), a<b<n, a major and b minor, ascending.
module rrm_pair_walk #(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [IW:0]   n,
    input  logic          step,
    output logic [IW-1:0] a,
    output logic [IW-1:0] b,
    output logic          last
);
    logic [IW:0] nreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            a    <= '0;
            b    <= '0;
            nreg <= '0;
        end else if (load) begin
            a    <= '0;
            b    <= IW'(1);
            nreg <= n;
        end else if (step) begin
            if ({1'b0, b} == nreg - (IW+1)'(1)) begin
                a <= a + IW'(1);
                b <= a + IW'(2);
            end else begin
                b <= b + IW'(1);
            end
        end
    end

    assign last = ({1'b0, a} == nreg - (IW+1)'(2)) && ({1'b0, b} == nreg - (IW+1)'(1));

    // R7: indices move only when a word is taken or a new walk begins
    assert_walk_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable({a, b}));
endmodule

// File: rtl/rrm_and.sv
`timescale 1ns/1ps
module rrm_and
    import rrm_pkg::*;
#(
    parameter int D = 4,
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [D*W-1:0] x_sh,
    input  logic [D*W-1:0] y_sh,
    input  logic [W-1:0]   rnd_data,
    input  logic           rnd_valid,
    output logic           rnd_ready,
    output logic [D*W-1:0] c_sh,
    output logic           done
);
    localparam int LOGD       = $clog2(D);
    localparam int KW         = 2 * LOGD;
    localparam int NW         = LOGD + 1;
    localparam int RAND_WORDS = rand_words(D);

    logic [W-1:0] xw [D];
    logic [W-1:0] yw [D];
    logic [W-1:0] cw [D];
    logic [W-1:0] mw [D][D];

    rrm_state_e      st;
    logic [KW-1:0]   k;
    logic            side;       // 0: x half being re-masked, 1: y half
    logic [LOGD-1:0] rxb, ryb;
    logic [NW-1:0]   rh;

    logic [LOGD-1:0] s_row, s_col, s_xb, s_yb;
    logic [NW-1:0]   s_half;
    logic            s_ref;

    logic            wk_load, wlast, take, last_leaf;
    logic [NW-1:0]   wk_n;
    logic [LOGD-1:0] wa, wb, ref_a, ref_b;

    rrm_leaf_sched #(.LOGD(LOGD)) u_sched (
        .k      (k),
        .row    (s_row),
        .col    (s_col),
        .remask (s_ref),
        .xbase  (s_xb),
        .ybase  (s_yb),
        .half   (s_half)
    );

    rrm_pair_walk #(.IW(LOGD)) u_walk (
        .clk  (clk),
        .rst  (rst),
        .load (wk_load),
        .n    (wk_n),
        .step (take),
        .a    (wa),
        .b    (wb),
        .last (wlast)
    );

    assign rnd_ready = (st == S_REF) || (st == S_CPAIR);
    assign take      = rnd_valid && rnd_ready;
    assign last_leaf = &k;
    assign ref_a     = (side ? ryb : rxb) + wa;
    assign ref_b     = (side ? ryb : rxb) + wb;

    always_comb begin
        wk_load = 1'b0;
        wk_n    = NW'(D);
        case (st)
            S_LEAF: begin
                wk_load = s_ref && !last_leaf;
                wk_n    = s_half;
            end
            S_REF: begin
                wk_load = take && wlast && !side;
                wk_n    = rh;
            end
            S_CINIT: wk_load = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            k    <= '0;
            side <= 1'b0;
            rxb  <= '0;
            ryb  <= '0;
            rh   <= '0;
            done <= 1'b0;
            for (int i = 0; i < D; i++) cw[i] <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start) begin
                        for (int i = 0; i < D; i++) begin
                            xw[i] <= x_sh[i*W +: W];
                            yw[i] <= y_sh[i*W +: W];
                        end
                        k  <= '0;
                        st <= S_LEAF;
                    end
                end
                S_LEAF: begin
                    mw[s_row][s_col] <= xw[s_row] & yw[s_col];
                    if (last_leaf) begin
                        st <= S_CINIT;
                    end else begin
                        k <= k + KW'(1);
                        if (s_ref) begin
                            rxb  <= s_xb;
                            ryb  <= s_yb;
                            rh   <= s_half;
                            side <= 1'b0;
                            st   <= S_REF;
                        end
                    end
                end
                S_REF: begin
                    if (take) begin
                        if (side) begin
                            yw[ref_a] <= yw[ref_a] ^ rnd_data;
                            yw[ref_b] <= yw[ref_b] ^ rnd_data;
                        end else begin
                            xw[ref_a] <= xw[ref_a] ^ rnd_data;
                            xw[ref_b] <= xw[ref_b] ^ rnd_data;
                        end
                        if (wlast) begin
                            if (side) st <= S_LEAF;
                            else side <= 1'b1;
                        end
                    end
                end
                S_CINIT: begin
                    for (int i = 0; i < D; i++) cw[i] <= mw[i][i];
                    st <= S_CPAIR;
                end
                S_CPAIR: begin
                    if (take) begin
                        cw[wa] <= cw[wa] ^ rnd_data;
                        cw[wb] <= cw[wb] ^ rnd_data ^ mw[wa][wb] ^ mw[wb][wa];
                        if (wlast) begin
                            st   <= S_IDLE;
                            done <= 1'b1;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    for (genvar gi = 0; gi < D; gi++) begin : g_out
        assign c_sh[gi*W +: W] = cw[gi];
    end

    // ---------------- assertions ----------------
    logic [W-1:0] xfold, yfold, cfold;
    logic [15:0]  used_cnt;

    always_comb begin
        xfold = '0;
        yfold = '0;
        cfold = '0;
        for (int i = 0; i < D; i++) begin
            xfold ^= xw[i];
            yfold ^= yw[i];
            cfold ^= cw[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) used_cnt <= '0;
        else if (st == S_IDLE && start) used_cnt <= '0;
        else if (take) used_cnt <= used_cnt + 16'd1;
    end

    // R4: re-masking never alters the secret carried by the working shares
    assert_remask_x_R4: assert property (@(posedge clk) disable iff (rst)
        (st != S_IDLE) |=> (xfold == $past(xfold)));
    assert_remask_y_R4: assert property (@(posedge clk) disable iff (rst)
        (st != S_IDLE) |=> (yfold == $past(yfold)));
    // R5: each compression step adds exactly the two off-diagonal products
    assert_compress_step_R5: assert property (@(posedge clk) disable iff (rst)
        (st == S_CPAIR && take) |=> (cfold == $past(cfold ^ mw[wa][wb] ^ mw[wb][wa])));
    // R6: random budget per operation
    assert_rand_budget_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (used_cnt == 16'(RAND_WORDS)));
    // R8: single-cycle completion pulse, result held while idle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE) |=> $stable(c_sh));
endmodule

// File: tb/rrm_bench_core.sv
`timescale 1ns/1ps
module rrm_bench_core #(
    parameter int D = 4
) (
    input  logic clk,
    output logic fin,
    output int   nchk,
    output int   nfail
);
    localparam int W     = 32;
    localparam int LOGD  = $clog2(D);
    localparam int NRAND = (LOGD - 1) * D * D / 2 - (D / 2 - 1) * D + D * (D - 1) / 2;

    logic           rst, start, rv, rr, dn;
    logic [D*W-1:0] xs, ys, cs;
    logic [W-1:0]   rd;
    int             hcnt;
    int             mode;

    rrm_and #(.D(D), .W(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .x_sh(xs), .y_sh(ys),
        .rnd_data(rd), .rnd_valid(rv), .rnd_ready(rr), .c_sh(cs), .done(dn)
    );

    function automatic logic [W-1:0] rword(input int n, input int md);
        logic [W-1:0] z;
        if (md == 0) return '0;
        z = W'(n) * 32'h9E3779B9 + 32'h7F4A7C15;
        z = z ^ (z >> 15);
        z = z * 32'h2C1B3C6D;
        z = z ^ (z >> 12);
        return z;
    endfunction

    function automatic logic [W-1:0] foldv(input logic [D*W-1:0] v);
        logic [W-1:0] f;
        f = '0;
        for (int i = 0; i < D; i++) f ^= v[i*W +: W];
        return f;
    endfunction

    assign rd = rword(hcnt, mode);

    always @(posedge clk) begin
        if (rst) hcnt <= 0;
        else if (rv && rr) hcnt <= hcnt + 1;
    end

    // ---------- reference model: explicit-stack recursion ----------
    logic [W-1:0]   mx [D];
    logic [W-1:0]   my [D];
    logic [W-1:0]   mc [D];
    logic [W-1:0]   mm [D][D];
    logic [D*W-1:0] expc;
    int             rp;
    int fx [32];
    int fy [32];
    int fn [32];
    int fph [32];

    task automatic remask_x(input int base, input int n);
        for (int a = 0; a < n; a++)
            for (int b = a + 1; b < n; b++) begin
                logic [W-1:0] r;
                r = rword(rp, mode); rp++;
                mx[base+a] ^= r; mx[base+b] ^= r;
            end
    endtask

    task automatic remask_y(input int base, input int n);
        for (int a = 0; a < n; a++)
            for (int b = a + 1; b < n; b++) begin
                logic [W-1:0] r;
                r = rword(rp, mode); rp++;
                my[base+a] ^= r; my[base+b] ^= r;
            end
    endtask

    task automatic model_run(input logic [D*W-1:0] xi, input logic [D*W-1:0] yi, input int r0);
        int sp, t, h;
        for (int i = 0; i < D; i++) begin
            mx[i] = xi[i*W +: W];
            my[i] = yi[i*W +: W];
        end
        rp = r0;
        fx[0] = 0; fy[0] = 0; fn[0] = D; fph[0] = 0; sp = 1;
        while (sp > 0) begin
            t = sp - 1;
            if (fn[t] == 1) begin
                mm[fx[t]][fy[t]] = mx[fx[t]] & my[fy[t]];
                sp--;
            end else begin
                h = fn[t] / 2;
                case (fph[t])
                    0: begin fph[t] = 1;
                        fx[sp] = fx[t]; fy[sp] = fy[t]; fn[sp] = h; fph[sp] = 0; sp++; end
                    1: begin remask_x(fx[t], h); remask_y(fy[t], h); fph[t] = 2;
                        fx[sp] = fx[t]; fy[sp] = fy[t] + h; fn[sp] = h; fph[sp] = 0; sp++; end
                    2: begin fph[t] = 3;
                        fx[sp] = fx[t] + h; fy[sp] = fy[t]; fn[sp] = h; fph[sp] = 0; sp++; end
                    3: begin remask_x(fx[t] + h, h); remask_y(fy[t] + h, h); fph[t] = 4;
                        fx[sp] = fx[t] + h; fy[sp] = fy[t] + h; fn[sp] = h; fph[sp] = 0; sp++; end
                    default: sp--;
                endcase
            end
        end
        for (int i = 0; i < D; i++) mc[i] = mm[i][i];
        for (int i = 0; i < D; i++)
            for (int j = i + 1; j < D; j++) begin
                logic [W-1:0] s;
                s = rword(rp, mode); rp++;
                mc[i] ^= s;
                mc[j] ^= s ^ mm[i][j] ^ mm[j][i];
            end
        for (int i = 0; i < D; i++) expc[i*W +: W] = mc[i];
    endtask

    // ---------- checking ----------
    task automatic chk(input bit ok, input string req, input logic [D*W-1:0] got,
                       input logic [D*W-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s D=%0d got=%h exp=%h", req, D, got, exp);
        end
    endtask

    task automatic rvec(output logic [D*W-1:0] v);
        for (int i = 0; i < D; i++) v[i*W +: W] = $urandom;
    endtask

    task automatic run_case(input logic [D*W-1:0] xi, input logic [D*W-1:0] yi,
                            input int md, input bit stall, input bit poke);
        int h0, cyc;
        logic [D*W-1:0] held;
        @(negedge clk);
        xs = xi; ys = yi; mode = md; start = 1'b1; h0 = hcnt;
        cyc = 0;
        while (cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (dn) break;
            rv    = stall ? 1'($urandom % 2) : 1'b1;
            start = poke && (cyc == 3);
            if (start) begin xs = ~xi; ys = ~yi; end
        end
        start = 1'b0; rv = 1'b1;
        chk(dn == 1'b1, "R8 done seen", {{(D*W-1){1'b0}}, dn}, {{(D*W-1){1'b0}}, 1'b1});
        model_run(xi, yi, h0);
        // R3 R4 R5 R7 R9: every share matches the model of the recursion and compression
        chk(cs == expc, "R3/R5 exact shares", cs, expc);
        // R2: recombined result
        chk(foldv(cs) == (foldv(xi) & foldv(yi)), "R2 recombined AND",
            (D*W)'(foldv(cs)), (D*W)'(foldv(xi) & foldv(yi)));
        // R6: handshake count
        chk((hcnt - h0) == NRAND, "R6 random words", (D*W)'(hcnt - h0), (D*W)'(NRAND));
        held = cs;
        @(negedge clk);
        chk(dn == 1'b0 && cs == held, "R8 pulse/hold", cs, held);
        chk(rr == 1'b0, "R7 ready low idle", (D*W)'(rr), '0);
    endtask

    initial begin
        logic [D*W-1:0] a, b;
        int seed;
        fin = 1'b0; nchk = 0; nfail = 0;
        rst = 1'b1; start = 1'b0; rv = 1'b1; xs = '0; ys = '0; mode = 0;
        seed = $urandom(1234 + D);
        repeat (3) @(negedge clk);
        chk(dn == 1'b0 && rr == 1'b0 && cs == '0, "R1 reset", cs, '0);
        rst = 1'b0;
        @(negedge clk);
        chk(dn == 1'b0 && rr == 1'b0 && cs == '0, "R1 after reset", cs, '0);

        // R5: zero random stream, compression visible without masks
        rvec(a); rvec(b);
        run_case(a, b, 0, 1'b0, 1'b0);
        // R2: all-ones x shares, random y
        rvec(b);
        run_case('1, b, 1, 1'b0, 1'b0);
        // R2: all-zero sharings
        run_case('0, '0, 1, 1'b0, 1'b0);
        // R3 R4: hashed randoms, alternating stalls (R7)
        for (int it = 0; it < 5; it++) begin
            rvec(a); rvec(b);
            run_case(a, b, 1, it % 2 == 1, 1'b0);
        end
        // R9: start pulse while busy must be ignored
        rvec(a); rvec(b);
        run_case(a, b, 1, 1'b1, 1'b1);
        fin = 1'b1;
    end
endmodule

// File: tb/sim_rrm_and.sv
`timescale 1ns/1ps
module sim_rrm_and;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic f0, f1;
    int   c0, c1, e0, e1;

    rrm_bench_core #(.D(4)) u0 (.clk(clk), .fin(f0), .nchk(c0), .nfail(e0));
    rrm_bench_core #(.D(8)) u1 (.clk(clk), .fin(f1), .nchk(c1), .nfail(e1));

    initial begin
        int cyc, checks, fails;
        cyc = 0;
        @(posedge clk);
        while (!(f0 === 1'b1 && f1 === 1'b1) && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        checks = c0 + c1;
        fails  = e0 + e1;
        if (!(f0 === 1'b1 && f1 === 1'b1)) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired after %0d cycles", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule